// File: doc/BRIEF.md
# Nonvolatile Control Register Write Sequencer

This block decides whether each decoded write byte from a serial slave front end is accepted or refused. It also guards changes to an 8-bit configuration word. That word holds a watchdog period select, a block-protect bit and a power-up delay select. The front end presents one data byte per pulse of `wr_valid`. With it come a flag that picks the control register or the memory array, a flag that marks the first data byte of a transaction, and the memory address. One cycle later the block answers with an acknowledge or a no-acknowledge.

Two volatile latches gate every change. The write-enable latch must be set before memory or the register can be written. The register-write-enable latch must also be set before the configuration fields can change. Once both are set, a third control byte either commits the fields or only re-arms the latch. A commit starts a modelled nonvolatile programming cycle. During that cycle the block reports busy and refuses all writes. The block also tells the front end whether a given memory address lies in the protected upper half of the array.

Top module: `nvcfg_wr_seq`

## Requirements
- R1: After reset, both latches are 0, the watchdog select is 11, block-protect is 0, the power-up select is 01, busy is 0 and no answer is pending.
- R2: While the write-enable latch is 0, every write is refused and changes nothing. The only exception is a first control byte of 02h.
- R3: A first control byte of 02h sets the write-enable latch and is acknowledged. While the register-write-enable latch is 0, a first control byte of 00h with the write-enable latch set clears that latch and is acknowledged.
- R4: While the write-enable latch is 1 and the register-write-enable latch is 0, a first control byte of 06h sets the register-write-enable latch and is acknowledged. The register-write-enable latch is never 1 while the write-enable latch is 0.
- R5: While the register-write-enable latch is 1, a first control byte with bits [3:1] = 001 is acknowledged and loads the fields: watchdog select = {bit6, bit5}, block-protect = bit4, power-up select = {bit7, bit0}. It then clears the register-write-enable latch and leaves the write-enable latch set.
- R6: A commit holds `busy` high for exactly NV_CYCLES cycles. Any write that arrives while busy is refused and changes nothing.
- R7: While the register-write-enable latch is 1, a first control byte with bits [3:1] = 011 is acknowledged and changes nothing. Any other bit pattern is refused and changes nothing.
- R8: A control byte that is not the first data byte of its transaction is refused and changes nothing.
- R9: With the write-enable latch set, a memory write to a protected address is refused and clears the register-write-enable latch. A write to an unprotected address is acknowledged.
- R10: `prot_hit` is 1 exactly when block-protect is 1 and the MSB of `chk_addr` is 1, so the protected range is 100h to 1FFh.
- R11: `ack_valid` is high in the cycle after each `wr_valid` pulse and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, models power-up |
| wr_valid | input | 1 | One decoded data byte of a write |
| wr_ctrl | input | 1 | 1 = control register target, 0 = memory |
| wr_first | input | 1 | Byte is the first data byte of its transaction |
| wr_addr | input | ADDR_W | Memory address of the byte |
| wr_data | input | 8 | Data byte |
| chk_addr | input | ADDR_W | Address to test against the protected region |
| ack_valid | output | 1 | Answer for the previous byte is present |
| ack | output | 1 | 1 = acknowledge, 0 = no-acknowledge |
| busy | output | 1 | Nonvolatile cycle in progress |
| wel | output | 1 | Write-enable latch |
| rwel | output | 1 | Register-write-enable latch |
| wd_sel | output | 2 | Watchdog period select |
| blk_prot | output | 1 | Block-protect bit |
| pup_sel | output | 2 | Power-up delay select |
| prot_hit | output | 1 | `chk_addr` is write protected |

## Verification
The assertions check on every cycle that the answer timing holds and that the latch ordering holds. They also check that refusals during busy, while the write-enable latch is clear and for trailing control bytes leave all state unchanged. The field loading on a commit and the clearing of the latch on a protected write are checked the same way. Only the bench scenarios show the full staged orderings. These are the 02h/06h/02h sequence clearing every field, 02h/06h/06h keeping the latch armed, re-arming after a commit, and the exact length of the busy window. The bench runs these against its behavioural model on every clock.

// File: rtl/nvcfg_wr_seq.sv
module nvcfg_wr_seq #(
  parameter int ADDR_W = 9,
  parameter int NV_CYCLES = 20,
  parameter logic [1:0] WD_DEF = 2'b11,
  parameter logic [1:0] PUP_DEF = 2'b01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic              wr_ctrl,
  input  logic              wr_first,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              ack_valid,
  output logic              ack,
  output logic              busy,
  output logic              wel,
  output logic              rwel,
  output logic [1:0]        wd_sel,
  output logic              blk_prot,
  output logic [1:0]        pup_sel,
  output logic              prot_hit
);
  localparam int CNT_W = $clog2(NV_CYCLES + 1);
  localparam logic [7:0] CMD_ARM = 8'h02;
  localparam logic [7:0] CMD_REG = 8'h06;
  localparam logic [7:0] CMD_OFF = 8'h00;

  logic [CNT_W-1:0] nv_cnt;
  logic acc, set_wel, clr_wel, set_rwel, clr_rwel, do_commit;

  wire commit_pat = wr_data[3:1] == 3'b001;
  wire rearm_pat  = wr_data[3:1] == 3'b011;
  wire mem_prot   = blk_prot && wr_addr[ADDR_W-1];

  assign busy     = nv_cnt != '0;
  assign prot_hit = blk_prot && chk_addr[ADDR_W-1];

  always_comb begin
    acc = 1'b0; set_wel = 1'b0; clr_wel = 1'b0;
    set_rwel = 1'b0; clr_rwel = 1'b0; do_commit = 1'b0;
    if (wr_valid && !busy) begin
      if (wr_ctrl) begin
        if (wr_first) begin
          if (rwel) begin
            if (commit_pat) begin
              acc = 1'b1; do_commit = 1'b1; clr_rwel = 1'b1;
            end else if (rearm_pat) begin
              acc = 1'b1;
            end
          end else if (wr_data == CMD_ARM) begin
            acc = 1'b1; set_wel = 1'b1;
          end else if (wel && wr_data == CMD_REG) begin
            acc = 1'b1; set_rwel = 1'b1;
          end else if (wel && wr_data == CMD_OFF) begin
            acc = 1'b1; clr_wel = 1'b1;
          end
        end
      end else if (wel) begin
        if (mem_prot) clr_rwel = 1'b1;
        else acc = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_valid <= 1'b0;
      ack       <= 1'b0;
      wel       <= 1'b0;
      rwel      <= 1'b0;
      wd_sel    <= WD_DEF;
      blk_prot  <= 1'b0;
      pup_sel   <= PUP_DEF;
      nv_cnt    <= '0;
    end else begin
      ack_valid <= wr_valid;
      ack       <= acc;
      if (set_wel || set_rwel) wel <= 1'b1;
      else if (clr_wel) wel <= 1'b0;
      if (set_rwel) rwel <= 1'b1;
      else if (clr_rwel) rwel <= 1'b0;
      if (do_commit) begin
        wd_sel   <= wr_data[6:5];
        blk_prot <= wr_data[4];
        pup_sel  <= {wr_data[7], wr_data[0]};
        nv_cnt   <= CNT_W'(NV_CYCLES);
      end else if (busy) begin
        nv_cnt <= nv_cnt - 1'b1;
      end
    end
  end
endmodule

module nvcfg_wr_seq_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ctrl,
  input logic              wr_first,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              ack_valid,
  input logic              ack,
  input logic              busy,
  input logic              wel,
  input logic              rwel,
  input logic [1:0]        wd_sel,
  input logic              blk_prot,
  input logic [1:0]        pup_sel
);
  wire [6:0] st = {wel, rwel, wd_sel, blk_prot, pup_sel};

  assert_ans_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> ack_valid);
  assert_no_stray_ans_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> !ack_valid);
  assert_busy_refuse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && busy) |=> (!ack && $stable(st)));
  assert_busy_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable({wd_sel, blk_prot, pup_sel}));
  assert_locked_refuse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wel && !(wr_ctrl && wr_first && wr_data == 8'h02)) |=> (!ack && $stable(st)));
  assert_latch_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rwel |-> wel);
  assert_trailing_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ctrl && !wr_first) |=> (!ack && $stable(st)));
  assert_commit_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ctrl && wr_first && rwel && !busy && wr_data[3:1] == 3'b001)
    |=> (ack && !rwel && wel && busy && wd_sel == $past(wr_data[6:5])
         && blk_prot == $past(wr_data[4]) && pup_sel == {$past(wr_data[7]), $past(wr_data[0])}));
  assert_prot_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ctrl && wel && !busy && blk_prot && wr_addr[ADDR_W-1]) |=> (!ack && !rwel));
endmodule

bind nvcfg_wr_seq nvcfg_wr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ctrl(wr_ctrl),
  .wr_first(wr_first), .wr_addr(wr_addr), .wr_data(wr_data),
  .ack_valid(ack_valid), .ack(ack), .busy(busy), .wel(wel), .rwel(rwel),
  .wd_sel(wd_sel), .blk_prot(blk_prot), .pup_sel(pup_sel)
);

// File: tb/nvcfg_wr_seq_bench.sv
`timescale 1ns/1ps
module nvcfg_wr_seq_bench;
  localparam int AW = 9;
  localparam int NVC = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, wr_ctrl = 1'b0, wr_first = 1'b0;
  logic [AW-1:0] wr_addr = '0, chk_addr = '0;
  logic [7:0] wr_data = '0;
  logic ack_valid, ack, busy, wel, rwel, blk_prot, prot_hit;
  logic [1:0] wd_sel, pup_sel;

  int n_run = 0, n_fail = 0, cyc = 0;

  nvcfg_wr_seq #(.ADDR_W(AW), .NV_CYCLES(NVC)) u_nvcfg_wr_seq (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ctrl(wr_ctrl),
    .wr_first(wr_first), .wr_addr(wr_addr), .wr_data(wr_data),
    .chk_addr(chk_addr), .ack_valid(ack_valid), .ack(ack), .busy(busy),
    .wel(wel), .rwel(rwel), .wd_sel(wd_sel), .blk_prot(blk_prot),
    .pup_sel(pup_sel), .prot_hit(prot_hit));

  always #5 clk = ~clk;

  // behavioural reference model
  int m_wel, m_rwel, m_wd, m_bp, m_pup, m_left, m_av, m_ack;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wel = 0; m_rwel = 0; m_wd = 3; m_bp = 0; m_pup = 1;
      m_left = 0; m_av = 0; m_ack = 0;
    end else begin
      int ok;
      int d;
      ok = 0;
      d = int'(wr_data);
      m_av = wr_valid ? 1 : 0;
      if (wr_valid && m_left == 0) begin
        if (!wr_ctrl) begin
          if (m_wel == 1 && m_bp == 1 && int'(wr_addr) >= 256) m_rwel = 0;
          else if (m_wel == 1) ok = 1;
        end else if (wr_first) begin
          if (m_rwel == 1) begin
            if (((d / 2) % 8) == 1) begin
              ok = 1; m_rwel = 0; m_left = NVC + 1;
              m_wd = (d / 32) % 4; m_bp = (d / 16) % 2;
              m_pup = 2 * ((d / 128) % 2) + d % 2;
            end else if (((d / 2) % 8) == 3) ok = 1;
          end else if (d == 2) begin ok = 1; m_wel = 1; end
          else if (d == 6 && m_wel == 1) begin ok = 1; m_rwel = 1; end
          else if (d == 0 && m_wel == 1) begin ok = 1; m_wel = 0; end
        end
      end
      if (m_left > 0) m_left = m_left - 1;
      m_ack = ok;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R11 ack_valid", ack_valid, m_av);
      if (ack_valid) chk("R2/R3/R7 ack", ack, m_ack);
      chk("R3 wel", wel, m_wel);
      chk("R4 rwel", rwel, m_rwel);
      chk("R5 wd_sel", wd_sel, m_wd);
      chk("R5 blk_prot", blk_prot, m_bp);
      chk("R5 pup_sel", pup_sel, m_pup);
      chk("R6 busy", busy, m_left > 0 ? 1 : 0);
      chk("R10 prot_hit", prot_hit, (m_bp == 1 && chk_addr >= 256) ? 1 : 0);
    end
  end

  task automatic wr(bit c, bit f, int a, int d);
    @(negedge clk);
    wr_valid = 1'b1; wr_ctrl = c; wr_first = f;
    wr_addr = AW'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 wel", wel, 0); chk("R1 rwel", rwel, 0); chk("R1 wd", wd_sel, 3);
    chk("R1 bp", blk_prot, 0); chk("R1 pup", pup_sel, 1); chk("R1 busy", busy, 0);
    chk("R1 ack_valid", ack_valid, 0);
    // R2 locked
    wr(0, 1, 'h010, 'hAA); chk("R2 mem nack", ack, 0);
    wr(1, 1, 0, 'h06); chk("R2 06 nack", ack, 0); chk("R2 rwel", rwel, 0);
    // R3 arm / disarm
    wr(1, 1, 0, 'h02); chk("R3 ack", ack, 1); chk("R3 wel set", wel, 1);
    wr(1, 1, 0, 'h00); chk("R3 ack off", ack, 1); chk("R3 wel clr", wel, 0);
    wr(1, 1, 0, 'h02);
    // R4
    wr(1, 1, 0, 'h06); chk("R4 ack", ack, 1); chk("R4 rwel", rwel, 1);
    // R7 re-arm and bad pattern
    wr(1, 1, 0, 'h06); chk("R7 rearm ack", ack, 1); chk("R7 rwel kept", rwel, 1);
    chk("R7 wd kept", wd_sel, 3);
    wr(1, 1, 0, 'h55); chk("R7 bad nack", ack, 0); chk("R7 pup kept", pup_sel, 1);
    // R8 trailing byte
    wr(1, 0, 0, 'hB3); chk("R8 nack", ack, 0); chk("R8 wd kept", wd_sel, 3);
    chk("R8 rwel kept", rwel, 1);
    // R5 commit 1011_0011
    wr(1, 1, 0, 'hB3); chk("R5 ack", ack, 1); chk("R5 wd", wd_sel, 1);
    chk("R5 bp", blk_prot, 1); chk("R5 pup", pup_sel, 3); chk("R5 rwel", rwel, 0);
    chk("R5 wel", wel, 1); chk("R6 busy", busy, 1);
    // R6 refuse while busy
    wr(1, 1, 0, 'h06); chk("R6 busy nack", ack, 0); chk("R6 rwel", rwel, 0);
    idle(NVC - 3); chk("R6 still busy", busy, 1);
    idle(1); chk("R6 busy done", busy, 0);
    // R10
    chk_addr = 9'h100; idle(1); chk("R10 hit", prot_hit, 1);
    chk_addr = 9'h0FF; idle(1); chk("R10 miss", prot_hit, 0);
    // R9
    wr(1, 1, 0, 'h06); chk("R9 armed", rwel, 1);
    wr(0, 1, 'h1A0, 'h12); chk("R9 prot nack", ack, 0); chk("R9 rwel clr", rwel, 0);
    wr(0, 1, 'h050, 'h12); chk("R9 open ack", ack, 1);
    // R5: 02,06,02 clears all fields
    wr(1, 1, 0, 'h02); wr(1, 1, 0, 'h06); wr(1, 1, 0, 'h02);
    chk("R5 zero wd", wd_sel, 0); chk("R5 zero bp", blk_prot, 0); chk("R5 zero pup", pup_sel, 0);
    idle(NVC + 2);
    chk("R6 idle", busy, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule